// File: doc/BRIEF.md
# Single-Cycle Load/Store Core with Post-Increment Load

This block is a 32-bit processor core that finishes every instruction in one clock. It covers a small instruction subset:
- register-register arithmetic and logic;
- word load and word store;
- branch on equal;
- jump through a register;
- logical left shift by a constant;
- load of a 16-bit constant into the upper half of a register;
- a load with automatic index increment.

In one cycle, the indexed load puts the loaded word into one register and the index plus one into another. For this reason the register file has two write ports.

Instruction memory and data memory sit outside the core. The core drives the instruction address and reads the instruction word from the same cycle. It drives the data address, the write data and two strobes. Data memory answers a read within the cycle and commits a write on the rising clock edge. The asynchronous active-low reset is released into the core through a two-stage synchronizer. The program counter therefore starts advancing two edges after reset goes high.

Top module: `sc_core`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, the instruction address is 0 and the data write strobe is low.
- R2: Opcode 0x00 with function codes 0x20 (add), 0x22 (subtract), 0x24 (and), 0x25 (or) and 0x2A (signed set-less-than, result 1 or 0) writes the result of rs op rt into register rd (instruction bits 15:11).
- R3: Opcode 0x23 loads the word at address rs + sign-extended imm16 into rt (bits 20:16), including a negative offset.
- R4: Opcode 0x2B stores rt to address rs + sign-extended imm16 and writes no register.
- R5: Opcode 0x04 branches to PC+4 + (sign-extended imm16 << 2) when rs equals rt. Otherwise it falls through to PC+4.
- R6: Every instruction that is not a taken branch or a register jump advances the PC by 4.
- R7: Opcode 0x00 with function 0x08 sets the next PC to the value of rs and writes no register, even when rd is non-zero.
- R8: Opcode 0x00 with function 0x00 writes rt shifted left by the shift-amount field (bits 10:6) into rd.
- R9: Opcode 0x0F writes {imm16, 16'h0000} into rt.
- R10: Opcode 0x30 loads the word at imm16 (sign-extended) + R[rt] into rs (bits 25:21) and, in the same cycle, writes R[rt] + 1 into rt.
- R11: When opcode 0x30 names the same register as rs and rt, the loaded word is the value kept.
- R12: Register 0 always reads as zero. Writes to it from either write port are dropped, and the other port's write in the same instruction still takes place.
- R13: The data read strobe is high only for the two load opcodes, and it is never high together with the write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for a data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe, committed on the rising edge |
| dmem_re | output | 1 | Data read strobe |
| dmem_rdata | input | 32 | Load data for dmem_addr, same cycle |

## Verification
The assertions assume that the instruction word is always defined once the core runs. They also assume that the program uses only the listed encodings, so that the next-PC rules can be checked from the opcode and function fields alone. The stimulus loads every program into a memory pre-filled with a branch-to-self word and keeps all data addresses word-aligned inside the modelled memory. This means the core never fetches an undefined word and never reads outside the array. Each program ends in that self-loop, so the state after the run is stable when the bench examines memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LINC  = 6'h30;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {DST_RT, DST_RD, DST_RS} dst_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_UPPER} wb_e;
  typedef enum logic [1:0] {AOP_ADD = 2'b00, AOP_SUB = 2'b01, AOP_FUNCT = 2'b10} aop_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SHL} alu_e;

  typedef struct packed {
    dst_e dst;
    logic b_imm;
    logic a_from_rt;
    wb_e  wb;
    logic reg_wr;
    logic mem_rd;
    logic mem_wr;
    logic branch;
    aop_e aop;
    logic inc_wr;
  } ctrl_t;
endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{dst: DST_RT, b_imm: 1'b0, a_from_rt: 1'b0, wb: WB_ALU, reg_wr: 1'b0,
             mem_rd: 1'b0, mem_wr: 1'b0, branch: 1'b0, aop: AOP_ADD, inc_wr: 1'b0};
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst    = DST_RD;
        ctrl.reg_wr = 1'b1;
        ctrl.aop    = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.b_imm  = 1'b1;
        ctrl.wb     = WB_MEM;
        ctrl.reg_wr = 1'b1;
        ctrl.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aop    = AOP_SUB;
      end
      OP_LUI: begin
        ctrl.wb     = WB_UPPER;
        ctrl.reg_wr = 1'b1;
      end
      OP_LINC: begin
        ctrl.dst       = DST_RS;
        ctrl.b_imm     = 1'b1;
        ctrl.a_from_rt = 1'b1;
        ctrl.wb        = WB_MEM;
        ctrl.reg_wr    = 1'b1;
        ctrl.mem_rd    = 1'b1;
        ctrl.inc_wr    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  aop_e       aop,
  input  logic [5:0] funct,
  output alu_e       alu_op,
  output logic       is_jr
);
  always_comb begin
    alu_op = ALU_ADD;
    is_jr  = 1'b0;
    case (aop)
      AOP_SUB: alu_op = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          FN_SLL:  alu_op = ALU_SHL;
          FN_JR:   is_jr  = 1'b1;
          default: alu_op = ALU_ADD;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   shamt,
  input  alu_e         op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      ALU_SHL: y = b << shamt;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [W-1:0]  wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [W-1:0]  wd_b
);
  logic [NREG-1:0][W-1:0] bank;

  assign bank[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic         hit_a, hit_b;
    logic [W-1:0] q;
    assign hit_a = we_a && (wa_a == AW'(g));
    assign hit_b = we_b && (wa_b == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (hit_a) q <= wd_a;
      else if (hit_b) q <= wd_b;
    end
    assign bank[g] = q;
  end

  assign rd_a = bank[ra_a];
  assign rd_b = bank[ra_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata
);
  localparam int AW = $clog2(NREG);

  logic [1:0] rst_pipe;
  logic       core_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_run = rst_pipe[1];

  logic [5:0]   opcode, funct;
  logic [4:0]   f_rs, f_rt, f_rd, shamt;
  logic [15:0]  imm;
  logic [W-1:0] sext;

  assign opcode = imem_rdata[31:26];
  assign f_rs   = imem_rdata[25:21];
  assign f_rt   = imem_rdata[20:16];
  assign f_rd   = imem_rdata[15:11];
  assign shamt  = imem_rdata[10:6];
  assign funct  = imem_rdata[5:0];
  assign imm    = imem_rdata[15:0];
  assign sext   = {{(W-16){imm[15]}}, imm};

  ctrl_t ctrl;
  alu_e  alu_op;
  logic  is_jr;

  sc_main_ctrl u_main (.opcode(opcode), .ctrl(ctrl));
  sc_alu_ctrl  u_actl (.aop(ctrl.aop), .funct(funct), .alu_op(alu_op), .is_jr(is_jr));

  logic [W-1:0]  rs_val, rt_val, alu_a, alu_b, alu_y, wd_a, wd_b;
  logic          alu_zero, we_a, we_b;
  logic [AW-1:0] wa_a;

  assign alu_a = ctrl.a_from_rt ? rt_val : rs_val;
  assign alu_b = ctrl.b_imm ? sext : rt_val;

  sc_alu #(.W(W)) u_alu (
    .a(alu_a), .b(alu_b), .shamt(shamt), .op(alu_op), .y(alu_y), .zero(alu_zero)
  );

  always_comb begin
    case (ctrl.dst)
      DST_RD:  wa_a = AW'(f_rd);
      DST_RS:  wa_a = AW'(f_rs);
      default: wa_a = AW'(f_rt);
    endcase
    case (ctrl.wb)
      WB_MEM:   wd_a = dmem_rdata;
      WB_UPPER: wd_a = {imm, {(W-16){1'b0}}};
      default:  wd_a = alu_y;
    endcase
  end

  assign we_a = core_run && ctrl.reg_wr && !is_jr;
  assign we_b = core_run && ctrl.inc_wr;
  assign wd_b = rt_val + W'(1);

  sc_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(AW'(f_rs)), .ra_b(AW'(f_rt)), .rd_a(rs_val), .rd_b(rt_val),
    .we_a(we_a), .wa_a(wa_a), .wd_a(wd_a),
    .we_b(we_b), .wa_b(AW'(f_rt)), .wd_b(wd_b)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = core_run && ctrl.mem_wr;
  assign dmem_re    = core_run && ctrl.mem_rd;

  logic [W-1:0] pc_q, pc_next, pc_plus4, br_tgt;

  assign pc_plus4 = pc_q + W'(4);
  assign br_tgt   = pc_plus4 + (sext << 2);

  always_comb begin
    if (is_jr)                       pc_next = rs_val;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                              pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= RESET_PC;
    else if (core_run) pc_q <= pc_next;
  end

  assign imem_addr = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        run,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        dmem_we,
  input logic        dmem_re
);
  logic        is_beq, is_jr, is_ld;
  logic [31:0] beq_tgt;

  assign is_beq  = instr[31:26] == OP_BEQ;
  assign is_jr   = (instr[31:26] == OP_RTYPE) && (instr[5:0] == FN_JR);
  assign is_ld   = (instr[31:26] == OP_LW) || (instr[31:26] == OP_LINC);
  assign beq_tgt = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};

  p_pc_aligned_r6: assert property (@(posedge clk) disable iff (!run)
    pc[1:0] == 2'b00);

  p_seq_pc_r6: assert property (@(posedge clk) disable iff (!run)
    (!is_beq && !is_jr) |=> pc == $past(pc) + 32'd4);

  p_beq_taken_r5: assert property (@(posedge clk) disable iff (!run)
    (is_beq && rs_val == rt_val) |=> pc == $past(beq_tgt));

  p_beq_fall_r5: assert property (@(posedge clk) disable iff (!run)
    (is_beq && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  p_jr_target_r7: assert property (@(posedge clk) disable iff (!run)
    is_jr |=> pc == $past(rs_val));

  p_zero_rs_r12: assert property (@(posedge clk) disable iff (!run)
    (instr[25:21] == 5'd0) |-> rs_val == 32'd0);

  p_zero_rt_r12: assert property (@(posedge clk) disable iff (!run)
    (instr[20:16] == 5'd0) |-> rt_val == 32'd0);

  p_store_only_r4: assert property (@(posedge clk) disable iff (!run)
    dmem_we |-> instr[31:26] == OP_SW);

  p_read_only_load_r13: assert property (@(posedge clk) disable iff (!run)
    dmem_re |-> (is_ld && !dmem_we));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .run(core_run), .instr(imem_rdata), .pc(imem_addr),
  .rs_val(rs_val), .rt_val(rt_val), .dmem_we(dmem_we), .dmem_re(dmem_re)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  localparam logic [31:0] HALT = 32'h1000FFFF;

  always #4 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                        input int sh, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input int rs,
                                        input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prep();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      imem[i] = HALT;
      dmem[i] = 32'h77;
    end
  endtask

  task automatic run();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    prep();
    imem[0] = itype(6'h2B, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'h0);
    chk("R1 we in reset", {31'd0, dmem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc during release", imem_addr, 32'h0);
    chk("R1 we during release", {31'd0, dmem_we}, 32'h0);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_alu();
    prep();
    dmem[0] = 32'h13; dmem[1] = 32'hFFFFFFF9; dmem[2] = 32'd12;
    imem[0]  = itype(6'h23, 0, 1, 0);
    imem[1]  = itype(6'h23, 0, 2, 4);
    imem[2]  = rtype(1, 2, 3, 0, 6'h20);
    imem[3]  = rtype(1, 2, 4, 0, 6'h22);
    imem[4]  = rtype(1, 2, 5, 0, 6'h24);
    imem[5]  = rtype(1, 2, 6, 0, 6'h25);
    imem[6]  = rtype(2, 1, 7, 0, 6'h2A);
    imem[7]  = rtype(1, 2, 8, 0, 6'h2A);
    imem[8]  = itype(6'h2B, 0, 3, 64);
    imem[9]  = itype(6'h2B, 0, 4, 68);
    imem[10] = itype(6'h2B, 0, 5, 72);
    imem[11] = itype(6'h2B, 0, 6, 76);
    imem[12] = itype(6'h2B, 0, 7, 80);
    imem[13] = itype(6'h2B, 0, 8, 84);
    imem[14] = itype(6'h23, 0, 10, 8);
    imem[15] = itype(6'h23, 10, 9, -4);
    imem[16] = itype(6'h2B, 0, 9, 88);
    run();
    chk("R2 add", dmem[16], 32'd12);
    chk("R2 sub", dmem[17], 32'd26);
    chk("R2 and", dmem[18], 32'h11);
    chk("R2 or", dmem[19], 32'hFFFFFFFB);
    chk("R2 slt true", dmem[20], 32'd1);
    chk("R2 slt false", dmem[21], 32'd0);
    chk("R3 load negative offset", dmem[22], 32'd12);
    chk("R4 store left source word", dmem[0], 32'h13);
  endtask

  task automatic t_shift_upper();
    prep();
    dmem[0] = 32'h08000013;
    imem[0] = itype(6'h23, 0, 1, 0);
    imem[1] = rtype(0, 1, 2, 4, 6'h00);
    imem[2] = rtype(0, 1, 3, 0, 6'h00);
    imem[3] = itype(6'h0F, 0, 4, 16'hBEEF);
    imem[4] = itype(6'h2B, 0, 2, 64);
    imem[5] = itype(6'h2B, 0, 3, 68);
    imem[6] = itype(6'h2B, 0, 4, 72);
    run();
    chk("R8 sll by 4", dmem[16], 32'h80000130);
    chk("R8 sll by 0", dmem[17], 32'h08000013);
    chk("R9 lui", dmem[18], 32'hBEEF0000);
  endtask

  task automatic t_branch();
    prep();
    dmem[0] = 32'd5; dmem[1] = 32'd5; dmem[2] = 32'd6;
    imem[0]  = itype(6'h23, 0, 1, 0);
    imem[1]  = itype(6'h23, 0, 2, 4);
    imem[2]  = itype(6'h23, 0, 3, 8);
    imem[3]  = itype(6'h04, 1, 3, 1);
    imem[4]  = itype(6'h2B, 0, 1, 64);
    imem[5]  = itype(6'h04, 1, 2, 1);
    imem[6]  = itype(6'h2B, 0, 1, 68);
    imem[7]  = itype(6'h04, 0, 0, 2);
    imem[8]  = itype(6'h2B, 0, 1, 72);
    imem[9]  = itype(6'h2B, 0, 1, 72);
    imem[10] = itype(6'h2B, 0, 2, 76);
    run();
    chk("R5 not taken falls through", dmem[16], 32'd5);
    chk("R5 taken skips", dmem[17], 32'h77);
    chk("R5 taken by two skips both", dmem[18], 32'h77);
    chk("R6 target reached", dmem[19], 32'd5);
  endtask

  task automatic t_jr();
    prep();
    dmem[0] = 32'd24;
    imem[0] = itype(6'h23, 0, 5, 0);
    imem[1] = rtype(5, 0, 6, 0, 6'h08);
    imem[2] = itype(6'h2B, 0, 5, 64);
    imem[6] = itype(6'h2B, 0, 5, 68);
    imem[7] = itype(6'h2B, 0, 6, 72);
    run();
    chk("R7 jr skipped store", dmem[16], 32'h77);
    chk("R7 jr landed", dmem[17], 32'd24);
    chk("R7 jr no rd write", dmem[18], 32'd0);
  endtask

  task automatic t_linc();
    prep();
    dmem[0] = 32'd8; dmem[5] = 32'hCAFE0001;
    imem[0] = itype(6'h23, 0, 9, 0);
    imem[1] = itype(6'h30, 8, 9, 12);
    imem[2] = itype(6'h2B, 0, 8, 64);
    imem[3] = itype(6'h2B, 0, 9, 68);
    run();
    chk("R10 loaded word", dmem[16], 32'hCAFE0001);
    chk("R10 index incremented", dmem[17], 32'd9);
  endtask

  task automatic t_linc_same();
    prep();
    dmem[0] = 32'd8; dmem[5] = 32'hCAFE0001;
    imem[0] = itype(6'h23, 0, 9, 0);
    imem[1] = itype(6'h30, 9, 9, 12);
    imem[2] = itype(6'h2B, 0, 9, 64);
    run();
    chk("R11 load wins over increment", dmem[16], 32'hCAFE0001);
  endtask

  task automatic t_zero();
    prep();
    dmem[0] = 32'h55;
    imem[0] = itype(6'h23, 0, 1, 0);
    imem[1] = rtype(1, 1, 0, 0, 6'h20);
    imem[2] = itype(6'h2B, 0, 0, 64);
    imem[3] = itype(6'h30, 0, 2, 0);
    imem[4] = itype(6'h2B, 0, 0, 68);
    imem[5] = itype(6'h2B, 0, 2, 72);
    imem[6] = itype(6'h30, 3, 0, 0);
    imem[7] = itype(6'h2B, 0, 0, 76);
    imem[8] = itype(6'h2B, 0, 3, 80);
    run();
    chk("R12 r0 after add", dmem[16], 32'd0);
    chk("R12 r0 after linc load", dmem[17], 32'd0);
    chk("R12 increment kept", dmem[18], 32'd1);
    chk("R12 r0 after linc index", dmem[19], 32'd0);
    chk("R12 load kept", dmem[20], 32'h55);
    chk("R13 no read strobe at halt", {31'd0, dmem_re}, 32'd0);
    chk("R13 no write strobe at halt", {31'd0, dmem_we}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = HALT;
      dmem[i] = 32'd0;
    end
    t_reset();
    t_alu();
    t_shift_upper();
    t_branch();
    t_jr();
    t_linc();
    t_linc_same();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule